// File: doc/BRIEF.md
# Banked GPIO Pin Multiplexer

This block is the pad-level controller for 48 general-purpose pads, arranged as a lower bank of 32 pads and an upper bank of 16 pads. Software reaches a small register file over a plain read/write bus. Through it, software sets the direction and output data of each pad and chooses which on-chip function owns each pad: plain GPIO, the LED controller, a dedicated alternate peripheral, the wireless block, or the NAND flash overlay.

For every pad, the block resolves one owner. The owner's output-enable and output value then drive the pad through one register stage. A read of a data word returns the live levels of the pads. A read of any other mapped word returns the stored setting. Several conventions are unusual. The upper-bank word of each banked register sits one word below its lower-bank word. The wireless control bits select the wireless function when they are 0. A single overlay bit takes over a fixed, scattered set of pads for the NAND interface.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset, every register reads 0. Pads 0–31 have pad_oe = 0. Pads 32–47 follow wifi_oe/wifi_out, because a control bit of 0 selects the wireless function.
- R2: Direction is at 0x04 for pads 0–31 (bit p) and at 0x00 for pads 32–47 (bit p−32). Data is at 0x0C for pads 0–31 and at 0x08 for pads 32–47. Each word reads back independently of the other bank's word.
- R3: On a GPIO-owned pad, a direction bit of 1 gives pad_oe = 1 and a direction bit of 0 gives pad_oe = 0. pad_out equals the written data bit.
- R4: A read of a data word (0x0C or 0x08) returns the pad_in levels of that bank in the pads' bit positions, not the written data.
- R5: For pads 0–31, a bit of 1 in the mode register at 0x18 gives the pad to the alternate function: pad_oe = alt_oe[p] and pad_out = alt_out[p].
- R6: For pads 0–23, a bit of 1 in the LED register at 0x10 gives the pad to the LED controller: pad_oe = 1 and pad_out = led_drv[p]. The LED select takes priority over the mode select. Bits 24–31 of a write to 0x10 are dropped and read back as 0.
- R7: For pads 32–47, control register 0x1C bit (p−32) = 0 selects wifi_oe/wifi_out and bit = 1 selects GPIO.
- R8: While bit 2 of the base register at 0x38 is 1, pads 8, 12–23 and 27 take nand_oe/nand_out, overriding LED, mode and GPIO. All other pads are unaffected.
- R9: After a write accepted at a clock edge, the pad outputs change at the following clock edge, and not before. A change on a function input also reaches the pads one clock later.
- R10: Read data appears on bus_rdata one clock after the address is presented. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 48 | Pad input levels |
| pad_oe | output | 48 | Registered pad output enable |
| pad_out | output | 48 | Registered pad output value |
| led_drv | input | 24 | LED controller outputs for pads 0–23 |
| alt_oe | input | 32 | Alternate-function output enables, pads 0–31 |
| alt_out | input | 32 | Alternate-function output values, pads 0–31 |
| wifi_oe | input | 16 | Wireless-block output enables, pads 32–47 |
| wifi_out | input | 16 | Wireless-block output values, pads 32–47 |
| nand_oe | input | 48 | NAND overlay output enables, indexed by pad |
| nand_out | input | 48 | NAND overlay output values, indexed by pad |

## Verification
The bench writes and reads the upper-bank words at 0x00 and 0x08, separately from the lower-bank words. A design that swapped the bank addresses would corrupt the lower-bank pads. It checks the inverted wireless polarity with a split control word. A design with the wrong polarity would drive GPIO values on the wireless pads. The bench stacks LED, mode and NAND selections on the same pads to expose a wrong priority order. It also reads data words while the written data differs from pad_in, which catches a design that returns the data register. Finally, it samples the cycle right after a write, where a design without the output register stage would change the pads early.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

  typedef enum logic [2:0] {
    OWN_GPIO = 3'd0,
    OWN_LED  = 3'd1,
    OWN_ALT  = 3'd2,
    OWN_WIFI = 3'd3,
    OWN_NAND = 3'd4
  } pad_owner_t;

  // byte offsets of the lower-bank words; upper-bank words sit one word below
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_LED  = 8'h10;
  localparam logic [7:0] OFS_MODE = 8'h18;
  localparam logic [7:0] OFS_CTRL = 8'h1C;
  localparam logic [7:0] OFS_BASE = 8'h38;

endpackage

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PADS = 48,
  parameter int BANK_W   = 32,
  parameter int LED_PADS = 24,
  parameter int ADDR_W   = 8,
  parameter int NAND_BIT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BANK_W-1:0]     bus_wdata,
  output logic [BANK_W-1:0]     bus_rdata,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   dir_q,
  output logic [NUM_PADS-1:0]   dout_q,
  output logic [LED_PADS-1:0]   led_q,
  output logic [BANK_W-1:0]     mode_q,
  output logic [NUM_PADS-BANK_W-1:0] ctrl_q,
  output logic                  nand_on
);

  localparam int HI_W       = NUM_PADS - BANK_W;
  localparam int BANK_BYTES = BANK_W / 8;

  localparam logic [ADDR_W-1:0] A_DIR_LO  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_DIR_HI  = ADDR_W'(OFS_DIR) - ADDR_W'(BANK_BYTES);
  localparam logic [ADDR_W-1:0] A_DATA_LO = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DATA_HI = ADDR_W'(OFS_DATA) - ADDR_W'(BANK_BYTES);
  localparam logic [ADDR_W-1:0] A_LED     = ADDR_W'(OFS_LED);
  localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_BASE    = ADDR_W'(OFS_BASE);

  logic [BANK_W-1:0] base_q;
  logic [BANK_W-1:0] rd_next;
  logic              hit_any;

  assign nand_on = base_q[NAND_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dout_q <= '0;
      led_q  <= '0;
      mode_q <= '0;
      ctrl_q <= '0;
      base_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR_LO:  dir_q[BANK_W-1:0]         <= bus_wdata;
        A_DIR_HI:  dir_q[NUM_PADS-1:BANK_W]  <= bus_wdata[HI_W-1:0];
        A_DATA_LO: dout_q[BANK_W-1:0]        <= bus_wdata;
        A_DATA_HI: dout_q[NUM_PADS-1:BANK_W] <= bus_wdata[HI_W-1:0];
        A_LED:     led_q  <= bus_wdata[LED_PADS-1:0];
        A_MODE:    mode_q <= bus_wdata;
        A_CTRL:    ctrl_q <= bus_wdata[HI_W-1:0];
        A_BASE:    base_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    hit_any = 1'b1;
    case (bus_addr)
      A_DIR_LO:  rd_next = dir_q[BANK_W-1:0];
      A_DIR_HI:  rd_next = BANK_W'(dir_q[NUM_PADS-1:BANK_W]);
      A_DATA_LO: rd_next = pad_in[BANK_W-1:0];
      A_DATA_HI: rd_next = BANK_W'(pad_in[NUM_PADS-1:BANK_W]);
      A_LED:     rd_next = BANK_W'(led_q);
      A_MODE:    rd_next = mode_q;
      A_CTRL:    rd_next = BANK_W'(ctrl_q);
      A_BASE:    rd_next = base_q;
      default:   hit_any = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hit_any)) |-> (bus_rdata == '0)); // R10

  AST_DIR_HI_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr) && $past(bus_addr) == A_DIR_HI)
    |-> (dir_q[NUM_PADS-1:BANK_W] == $past(bus_wdata[HI_W-1:0]))); // R2

endmodule

// File: rtl/gpio_pinmux_sel.sv
module gpio_pinmux_sel
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PADS = 48,
  parameter int BANK_W   = 32,
  parameter int LED_PADS = 24,
  parameter logic [NUM_PADS-1:0] NAND_MASK = 48'h0000_08FF_F100
) (
  input  logic [NUM_PADS-1:0]        dir_q,
  input  logic [NUM_PADS-1:0]        dout_q,
  input  logic [LED_PADS-1:0]        led_q,
  input  logic [BANK_W-1:0]          mode_q,
  input  logic [NUM_PADS-BANK_W-1:0] ctrl_q,
  input  logic                       nand_on,
  input  logic [LED_PADS-1:0]        led_drv,
  input  logic [BANK_W-1:0]          alt_oe,
  input  logic [BANK_W-1:0]          alt_out,
  input  logic [NUM_PADS-BANK_W-1:0] wifi_oe,
  input  logic [NUM_PADS-BANK_W-1:0] wifi_out,
  input  logic [NUM_PADS-1:0]        nand_oe,
  input  logic [NUM_PADS-1:0]        nand_out,
  output pad_owner_t                 owner [NUM_PADS],
  output logic [NUM_PADS-1:0]        nxt_oe,
  output logic [NUM_PADS-1:0]        nxt_out
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic sel_led, sel_alt, sel_wifi;
    logic f_led_o, f_alt_oe, f_alt_o, f_wifi_oe, f_wifi_o;
    pad_owner_t own;

    if (p < BANK_W) begin : g_lo
      assign sel_alt   = mode_q[p];
      assign f_alt_oe  = alt_oe[p];
      assign f_alt_o   = alt_out[p];
      assign sel_wifi  = 1'b0;
      assign f_wifi_oe = 1'b0;
      assign f_wifi_o  = 1'b0;
      if (p < LED_PADS) begin : g_led
        assign sel_led = led_q[p];
        assign f_led_o = led_drv[p];
      end else begin : g_noled
        assign sel_led = 1'b0;
        assign f_led_o = 1'b0;
      end
    end else begin : g_hi
      assign sel_led   = 1'b0;
      assign f_led_o   = 1'b0;
      assign sel_alt   = 1'b0;
      assign f_alt_oe  = 1'b0;
      assign f_alt_o   = 1'b0;
      assign sel_wifi  = ~ctrl_q[p-BANK_W];   // inverted: 0 = wireless
      assign f_wifi_oe = wifi_oe[p-BANK_W];
      assign f_wifi_o  = wifi_out[p-BANK_W];
    end

    always_comb begin
      if (nand_on && NAND_MASK[p]) own = OWN_NAND;
      else if (sel_led)            own = OWN_LED;
      else if (sel_alt)            own = OWN_ALT;
      else if (sel_wifi)           own = OWN_WIFI;
      else                         own = OWN_GPIO;
    end

    always_comb begin
      case (own)
        OWN_NAND: begin nxt_oe[p] = nand_oe[p]; nxt_out[p] = nand_out[p]; end
        OWN_LED:  begin nxt_oe[p] = 1'b1;       nxt_out[p] = f_led_o;     end
        OWN_ALT:  begin nxt_oe[p] = f_alt_oe;   nxt_out[p] = f_alt_o;     end
        OWN_WIFI: begin nxt_oe[p] = f_wifi_oe;  nxt_out[p] = f_wifi_o;    end
        default:  begin nxt_oe[p] = dir_q[p];   nxt_out[p] = dout_q[p];   end
      endcase
    end

    assign owner[p] = own;
  end

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PADS = 48,
  parameter int BANK_W   = 32,
  parameter int LED_PADS = 24,
  parameter int ADDR_W   = 8,
  parameter int NAND_BIT = 2,
  parameter logic [NUM_PADS-1:0] NAND_MASK = 48'h0000_08FF_F100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BANK_W-1:0]          bus_wdata,
  output logic [BANK_W-1:0]          bus_rdata,
  input  logic [NUM_PADS-1:0]        pad_in,
  output logic [NUM_PADS-1:0]        pad_oe,
  output logic [NUM_PADS-1:0]        pad_out,
  input  logic [LED_PADS-1:0]        led_drv,
  input  logic [BANK_W-1:0]          alt_oe,
  input  logic [BANK_W-1:0]          alt_out,
  input  logic [NUM_PADS-BANK_W-1:0] wifi_oe,
  input  logic [NUM_PADS-BANK_W-1:0] wifi_out,
  input  logic [NUM_PADS-1:0]        nand_oe,
  input  logic [NUM_PADS-1:0]        nand_out
);

  localparam int HI_W = NUM_PADS - BANK_W;

  logic [NUM_PADS-1:0] dir_q, dout_q, nxt_oe, nxt_out;
  logic [LED_PADS-1:0] led_q;
  logic [BANK_W-1:0]   mode_q;
  logic [HI_W-1:0]     ctrl_q;
  logic                nand_on;
  pad_owner_t          owner [NUM_PADS];

  gpio_pinmux_regs #(
    .NUM_PADS(NUM_PADS), .BANK_W(BANK_W), .LED_PADS(LED_PADS),
    .ADDR_W(ADDR_W), .NAND_BIT(NAND_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .dir_q(dir_q), .dout_q(dout_q), .led_q(led_q), .mode_q(mode_q),
    .ctrl_q(ctrl_q), .nand_on(nand_on)
  );

  gpio_pinmux_sel #(
    .NUM_PADS(NUM_PADS), .BANK_W(BANK_W), .LED_PADS(LED_PADS),
    .NAND_MASK(NAND_MASK)
  ) u_sel (
    .dir_q(dir_q), .dout_q(dout_q), .led_q(led_q), .mode_q(mode_q),
    .ctrl_q(ctrl_q), .nand_on(nand_on), .led_drv(led_drv),
    .alt_oe(alt_oe), .alt_out(alt_out), .wifi_oe(wifi_oe),
    .wifi_out(wifi_out), .nand_oe(nand_oe), .nand_out(nand_out),
    .owner(owner), .nxt_oe(nxt_oe), .nxt_out(nxt_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= nxt_oe;
      pad_out <= nxt_out;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pad_oe[BANK_W-1:0] == '0)); // R1

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
    AST_NAND_SEIZE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(owner[p] == OWN_NAND))
      |-> (pad_oe[p] == $past(nand_oe[p]) && pad_out[p] == $past(nand_out[p]))); // R8

    AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(owner[p] == OWN_GPIO))
      |-> (pad_oe[p] == $past(dir_q[p]) && pad_out[p] == $past(dout_q[p]))); // R3

    if (p >= BANK_W) begin : g_hi
      AST_WIFI_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(owner[p] != OWN_NAND) && !$past(ctrl_q[p-BANK_W]))
        |-> (pad_oe[p] == $past(wifi_oe[p-BANK_W]))); // R7
    end
  end

endmodule

// File: tb/gpio_pinmux_test.sv
`timescale 1ns/1ps
module gpio_pinmux_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [47:0] pad_in, pad_oe, pad_out, nand_oe, nand_out;
  logic [23:0] led_drv;
  logic [31:0] alt_oe, alt_out;
  logic [15:0] wifi_oe, wifi_out;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  gpio_pinmux uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .led_drv(led_drv),
    .alt_oe(alt_oe), .alt_out(alt_out), .wifi_oe(wifi_oe),
    .wifi_out(wifi_out), .nand_oe(nand_oe), .nand_out(nand_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 lower pad_oe", 64'(pad_oe[31:0]), 64'h0);
    chk("R1 upper pad_oe wireless", 64'(pad_oe[47:32]), 64'h1234);
    chk("R1 upper pad_out wireless", 64'(pad_out[47:32]), 64'h00FF);
    rd(8'h04, v); chk("R1 dir read", 64'(v), 64'h0);
    rd(8'h1C, v); chk("R1 ctrl read", 64'(v), 64'h0);
    rd(8'h38, v); chk("R1 base read", 64'(v), 64'h0);
  endtask

  task automatic t_gpio_lo();
    wr(8'h04, 32'h0000_00F0);
    wr(8'h0C, 32'h0000_00A0);
    settle();
    chk("R3 lower pad_oe", 64'(pad_oe[31:0]), 64'hF0);
    chk("R3 lower pad_out", 64'(pad_out[31:0]), 64'hA0);
  endtask

  task automatic t_timing();
    wr(8'h04, 32'h0000_00F1);
    chk("R9 no change at write edge", 64'(pad_oe[0]), 64'h0);
    @(negedge clk);
    chk("R9 change one edge later", 64'(pad_oe[0]), 64'h1);
    wr(8'h04, 32'h0000_00F0);
    settle();
  endtask

  task automatic t_upper();
    logic [31:0] v;
    wr(8'h1C, 32'h0000_FFFF);
    wr(8'h00, 32'h0000_0003);
    wr(8'h08, 32'h0000_0001);
    settle();
    chk("R7 ctrl=1 gives GPIO oe", 64'(pad_oe[47:32]), 64'h0003);
    chk("R2 upper data to pads", 64'(pad_out[47:32]), 64'h0001);
    chk("R2 lower bank untouched", 64'(pad_oe[31:0]), 64'hF0);
    rd(8'h00, v); chk("R2 upper dir read", 64'(v), 64'h3);
    rd(8'h04, v); chk("R2 lower dir read", 64'(v), 64'hF0);
  endtask

  task automatic t_wifi();
    logic [31:0] v;
    @(negedge clk);
    wifi_oe = 16'hA5A5; wifi_out = 16'h0F0F;
    wr(8'h1C, 32'h0000_00FF);
    settle();
    chk("R7 split oe", 64'(pad_oe[47:32]), 64'hA503);
    chk("R7 split out", 64'(pad_out[47:32]), 64'h0F01);
    rd(8'h1C, v); chk("R7 ctrl read", 64'(v), 64'hFF);
  endtask

  task automatic t_data_read();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 48'h1234_89AB_CDEF;
    rd(8'h0C, v); chk("R4 lower data read", 64'(v), 64'h89AB_CDEF);
    rd(8'h08, v); chk("R4 upper data read", 64'(v), 64'h1234);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h14, v); chk("R10 unmapped 0x14", 64'(v), 64'h0);
    rd(8'h3C, v); chk("R10 unmapped 0x3C", 64'(v), 64'h0);
  endtask

  task automatic t_alt();
    logic [31:0] v;
    @(negedge clk);
    alt_oe = 32'hFFFF_FFFF; alt_out = 32'h0000_0500;
    wr(8'h18, 32'h0000_0F00);
    settle();
    chk("R5 alt oe", 64'(pad_oe[31:0]), 64'hFF0);
    chk("R5 alt out", 64'(pad_out[31:0]), 64'h5A0);
    rd(8'h18, v); chk("R5 mode read", 64'(v), 64'hF00);
  endtask

  task automatic t_led();
    logic [31:0] v;
    @(negedge clk);
    led_drv = 24'h000200;
    wr(8'h10, 32'hFF00_0300);
    settle();
    chk("R6 led oe", 64'(pad_oe[31:0]), 64'hFF0);
    chk("R6 led over mode out", 64'(pad_out[31:0]), 64'h6A0);
    rd(8'h10, v); chk("R6 upper led bits dropped", 64'(v), 64'h300);
  endtask

  task automatic t_nand();
    @(negedge clk);
    nand_oe = '1; nand_out = '1;
    wr(8'h38, 32'h0000_0004);
    settle();
    chk("R8 nand oe", 64'(pad_oe[31:0]), 64'h08FF_FFF0);
    chk("R8 nand out", 64'(pad_out[31:0]), 64'h08FF_F7A0);
    chk("R8 upper unaffected", 64'(pad_oe[47:32]), 64'hA503);
    wr(8'h38, 32'h0000_0003);
    settle();
    chk("R8 overlay released oe", 64'(pad_oe[31:0]), 64'hFF0);
    chk("R8 overlay released out", 64'(pad_out[31:0]), 64'h6A0);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    pad_in = '0; led_drv = '0; alt_oe = '0; alt_out = '0;
    wifi_oe = 16'h1234; wifi_out = 16'h00FF; nand_oe = '0; nand_out = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_gpio_lo();
    t_timing();
    t_upper();
    t_wifi();
    t_data_read();
    t_unmapped();
    t_alt();
    t_led();
    t_nand();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule